// File: doc/BRIEF.md
# Ethernet Pause Flow-Control Timers

This block holds the two countdown timers behind full-duplex pause flow control in an Ethernet MAC. The peer timer takes the quanta carried by a pause frame received from the far end. It counts down once per slot-time tick, and while it is nonzero it holds the local transmitter off. The congestion timer serves the opposite direction. When local receive congestion appears, the block asks the transmit path to send a pause frame advertising the largest possible pause time. Each time such a frame is acknowledged as sent, the timer reloads to a value a little below that advertised time. When the timer runs out while congestion persists, the block asks for another pause frame, so the far end is refreshed before its own pause expires.

Both counts are presented as 32-bit read-only status words. Frame parsing, frame building and CRC belong to neighbouring logic. That logic supplies the slot tick, the received-pause event and the send acknowledge, and it consumes the request, the advertised time and the transmit enable.

Top module: `pause_flow_timers`

## Requirements
- R1: After reset, both status words read 0, `pause_req` is 0 and `tx_enable` is 1.
- R2: Each status word carries its 16-bit timer in bits 15:0, and bits 31:16 always read 0.
- R3: A `pause_sent_ack` that arrives while `pause_req` is high sets the congestion timer to `REFRESH_LOAD` and clears `pause_req`. Both changes are visible one cycle later. This load wins over a slot tick in the same cycle.
- R4: `pause_time` always presents `ADVERT_TIME`, which defaults to 16'hFFFF.
- R5: On each cycle with `slot_tick` high and no load, each nonzero timer decreases by exactly one. A timer at 0 stays at 0.
- R6: The first cycle that `congested` is high after being low raises `pause_req` one cycle later.
- R7: While `congested` is high, a slot tick that takes the congestion timer from 1 to 0 raises `pause_req` in the same cycle in which the count reads 0.
- R8: While `congested` is low, no new `pause_req` is raised, and the congestion timer keeps counting down to 0.
- R9: `rx_pause_valid` loads the peer timer with `rx_pause_quanta` one cycle later. This load wins over a slot tick in the same cycle.
- R10: `tx_enable` is 0 exactly in the cycles in which the peer timer is nonzero. A quanta of 0 gives `tx_enable` = 1 one cycle after the event.
- R11: `pause_req` stays high until it is acknowledged. A `pause_sent_ack` that arrives while `pause_req` is low leaves the congestion timer and `pause_req` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | One-cycle strobe, once per slot time |
| rx_pause_valid | input | 1 | One-cycle strobe: a pause frame was received |
| rx_pause_quanta | input | TMR_W | Pause quanta carried by that frame |
| congested | input | 1 | Local receive path is congested |
| pause_sent_ack | input | 1 | One-cycle strobe: the requested pause frame went out |
| pause_req | output | 1 | Request to transmit a pause frame |
| pause_time | output | TMR_W | Pause time to place in the outgoing frame |
| tx_enable | output | 1 | Frame transmission allowed |
| peer_stat | output | STAT_W | Status word holding the peer timer |
| cong_stat | output | STAT_W | Status word holding the congestion timer |

## Verification
The bench builds the block with `REFRESH_LOAD` = 16'h0014 and keeps the 16-bit timer width and the 16'hFFFF advertised time. With this short reload, a full reload-and-expire cycle takes only a few dozen slot ticks. Repeated refresh requests under sustained congestion, and run-down after congestion clears, therefore appear many times within the run. Random quanta are mostly drawn small, so the peer timer also reaches zero often. Full-range values are still used so that bits 15:0 of the status word are exercised across their whole width.

// File: rtl/pft_pkg.sv
package pft_pkg;
  localparam int unsigned PFT_TMR_W  = 16;
  localparam int unsigned PFT_STAT_W = 32;

  typedef enum logic [1:0] {
    CT_HOLD   = 2'd0,
    CT_LOAD   = 2'd1,
    CT_COUNT  = 2'd2
  } ct_action_e;
endpackage

// File: rtl/pft_peer_timer.sv
module pft_peer_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_tick,
  input  logic             load_en,
  input  logic [TMR_W-1:0] load_val,
  output logic [TMR_W-1:0] count,
  output logic             tx_en
);
  logic [TMR_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = count;
    if (load_en)
      cnt_nxt = load_val;
    else if (slot_tick && (count != '0))
      cnt_nxt = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      tx_en <= 1'b1;
    end else begin
      count <= cnt_nxt;
      tx_en <= (cnt_nxt == '0);
    end
  end

  a_r9_quanta_load: assert property (@(posedge clk) disable iff (rst)
    load_en |=> count == $past(load_val));
  a_r5_peer_dec: assert property (@(posedge clk) disable iff (rst)
    (slot_tick && !load_en && count != '0) |=> count == $past(count) - 1'b1);
  a_r5_peer_floor: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !load_en) |=> count == '0);
  a_r10_gate: assert property (@(posedge clk) disable iff (rst)
    tx_en == (count == '0));
endmodule

// File: rtl/pft_cong_timer.sv
module pft_cong_timer
  import pft_pkg::*;
#(
  parameter int unsigned      TMR_W        = 16,
  parameter logic [TMR_W-1:0] REFRESH_LOAD = 16'hFF00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_tick,
  input  logic             congested,
  input  logic             sent_ack,
  output logic [TMR_W-1:0] count,
  output logic             req
);
  logic       cong_q;
  logic       cong_rise;
  logic       expiring;
  ct_action_e act;

  assign cong_rise = congested && !cong_q;
  assign expiring  = congested && slot_tick && (count == TMR_W'(1));

  always_comb begin
    if (sent_ack && req)
      act = CT_LOAD;
    else if (slot_tick && (count != '0))
      act = CT_COUNT;
    else
      act = CT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      req    <= 1'b0;
      cong_q <= 1'b0;
    end else begin
      cong_q <= congested;
      unique case (act)
        CT_LOAD:  count <= REFRESH_LOAD;
        CT_COUNT: count <= count - 1'b1;
        default:  count <= count;
      endcase
      if (act == CT_LOAD)
        req <= 1'b0;
      else if (cong_rise || expiring)
        req <= 1'b1;
    end
  end

  a_r3_ack_load: assert property (@(posedge clk) disable iff (rst)
    (sent_ack && req) |=> (count == REFRESH_LOAD) && !req);
  a_r11_hold_req: assert property (@(posedge clk) disable iff (rst)
    (req && !sent_ack) |=> req);
  a_r8_no_req_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> $past(congested));
  a_r5_cong_dec: assert property (@(posedge clk) disable iff (rst)
    (slot_tick && !(sent_ack && req) && count != '0) |=> count == $past(count) - 1'b1);
  a_r11_stray_ack: assert property (@(posedge clk) disable iff (rst)
    (sent_ack && !req && !slot_tick) |=> $stable(count));
endmodule

// File: rtl/pft_stat_pack.sv
module pft_stat_pack #(
  parameter int unsigned TMR_W  = 16,
  parameter int unsigned STAT_W = 32
) (
  input  logic [TMR_W-1:0]  value,
  output logic [STAT_W-1:0] word
);
  localparam int unsigned PAD_W = STAT_W - TMR_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = {{PAD_W{1'b0}}, value};
    end else begin : g_nopad
      assign word = value[STAT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pause_flow_timers.sv
module pause_flow_timers
  import pft_pkg::*;
#(
  parameter int unsigned      TMR_W        = PFT_TMR_W,
  parameter int unsigned      STAT_W       = PFT_STAT_W,
  parameter logic [TMR_W-1:0] REFRESH_LOAD = 16'hFF00,
  parameter logic [TMR_W-1:0] ADVERT_TIME  = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_tick,
  input  logic              rx_pause_valid,
  input  logic [TMR_W-1:0]  rx_pause_quanta,
  input  logic              congested,
  input  logic              pause_sent_ack,
  output logic              pause_req,
  output logic [TMR_W-1:0]  pause_time,
  output logic              tx_enable,
  output logic [STAT_W-1:0] peer_stat,
  output logic [STAT_W-1:0] cong_stat
);
  logic [TMR_W-1:0] peer_cnt;
  logic [TMR_W-1:0] cong_cnt;

  assign pause_time = ADVERT_TIME;

  pft_peer_timer #(.TMR_W(TMR_W)) u_peer (
    .clk       (clk),
    .rst       (rst),
    .slot_tick (slot_tick),
    .load_en   (rx_pause_valid),
    .load_val  (rx_pause_quanta),
    .count     (peer_cnt),
    .tx_en     (tx_enable)
  );

  pft_cong_timer #(.TMR_W(TMR_W), .REFRESH_LOAD(REFRESH_LOAD)) u_cong (
    .clk       (clk),
    .rst       (rst),
    .slot_tick (slot_tick),
    .congested (congested),
    .sent_ack  (pause_sent_ack),
    .count     (cong_cnt),
    .req       (pause_req)
  );

  pft_stat_pack #(.TMR_W(TMR_W), .STAT_W(STAT_W)) u_peer_stat (
    .value (peer_cnt),
    .word  (peer_stat)
  );

  pft_stat_pack #(.TMR_W(TMR_W), .STAT_W(STAT_W)) u_cong_stat (
    .value (cong_cnt),
    .word  (cong_stat)
  );

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (peer_stat[STAT_W-1:TMR_W] == '0) && (cong_stat[STAT_W-1:TMR_W] == '0));
  a_r6_rise_req: assert property (@(posedge clk) disable iff (rst)
    (congested && !$past(congested) && !(pause_sent_ack && pause_req)) |=> pause_req);
endmodule

// File: tb/pause_flow_timers_test.sv
`timescale 1ns/1ps
module pause_flow_timers_test;
  localparam int unsigned      TMR_W = 16;
  localparam int unsigned      STAT_W = 32;
  localparam logic [TMR_W-1:0] RL = 16'h0014;
  localparam logic [TMR_W-1:0] AT = 16'hFFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_tick = 1'b0;
  logic rx_pause_valid = 1'b0;
  logic [TMR_W-1:0] rx_pause_quanta = '0;
  logic congested = 1'b0;
  logic pause_sent_ack = 1'b0;
  logic pause_req;
  logic [TMR_W-1:0] pause_time;
  logic tx_enable;
  logic [STAT_W-1:0] peer_stat;
  logic [STAT_W-1:0] cong_stat;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [TMR_W-1:0] m_peer = '0;
  logic [TMR_W-1:0] m_cong = '0;
  logic m_req = 1'b0;
  logic m_cq = 1'b0;

  always #2.5 clk = ~clk;

  pause_flow_timers #(.REFRESH_LOAD(RL), .ADVERT_TIME(AT)) uut (
    .clk(clk), .rst(rst), .slot_tick(slot_tick), .rx_pause_valid(rx_pause_valid),
    .rx_pause_quanta(rx_pause_quanta), .congested(congested),
    .pause_sent_ack(pause_sent_ack), .pause_req(pause_req), .pause_time(pause_time),
    .tx_enable(tx_enable), .peer_stat(peer_stat), .cong_stat(cong_stat)
  );

  function automatic logic [TMR_W-1:0] peer_next(logic [TMR_W-1:0] c, logic ld,
                                                   logic [TMR_W-1:0] q, logic tk);
    if (ld) return q;
    if (tk && c != 0) return c - 1'b1;
    return c;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, "/R2 peer_stat"}, peer_stat, {16'h0, m_peer});
    chk({tag, "/R2 cong_stat"}, cong_stat, {16'h0, m_cong});
    chk({tag, " pause_req"}, {31'h0, pause_req}, {31'h0, m_req});
    chk({tag, "/R10 tx_enable"}, {31'h0, tx_enable}, {31'h0, (m_peer == 0)});
    chk("R4 pause_time", {16'h0, pause_time}, {16'h0, AT});
  endtask

  // advance one clock, update model from the inputs applied, compare after edge
  task automatic step(string tag);
    logic ld_c;
    @(posedge clk);
    ld_c = pause_sent_ack && m_req;
    m_peer = peer_next(m_peer, rx_pause_valid, rx_pause_quanta, slot_tick);
    if (ld_c) begin
      m_cong = RL;
      m_req = 1'b0;
    end else begin
      if ((congested && !m_cq) || (congested && slot_tick && m_cong == 1)) m_req = 1'b1;
      if (slot_tick && m_cong != 0) m_cong = m_cong - 1'b1;
    end
    m_cq = congested;
    #1;
    check_all(tag);
    slot_tick = 1'b0;
    rx_pause_valid = 1'b0;
    pause_sent_ack = 1'b0;
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) begin
      slot_tick = 1'b1;
      step(tag);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check_all("R1");
    step("R1");

    // R6: congestion rise raises a request
    congested = 1'b1;
    step("R6");
    // R11: held without ack, even with ticks at count zero
    ticks(3, "R11");
    // R3: ack loads reload value
    pause_sent_ack = 1'b1;
    slot_tick = 1'b1;
    step("R3");
    chk("R3 load value", cong_stat, {16'h0, RL});
    // R5 / R7: count down to zero, request re-raised
    ticks(int'(RL), "R7");
    chk("R7 req at zero", {31'h0, pause_req}, 32'h1);
    step("R11");
    pause_sent_ack = 1'b1;
    step("R3");
    // R8: clear congestion, run down, no request
    congested = 1'b0;
    ticks(int'(RL) + 3, "R8");
    chk("R8 no req", {31'h0, pause_req}, 32'h0);
    // R11: stray ack ignored
    pause_sent_ack = 1'b1;
    step("R11");
    chk("R11 stray ack", cong_stat, 32'h0);

    // R9: load beats tick
    rx_pause_valid = 1'b1;
    rx_pause_quanta = 16'h0005;
    slot_tick = 1'b1;
    step("R9");
    chk("R9 load over tick", peer_stat, 32'h5);
    ticks(2, "R5");
    // R10: zero quanta re-enables next cycle
    rx_pause_valid = 1'b1;
    rx_pause_quanta = 16'h0000;
    step("R10");
    chk("R10 zero quanta", {31'h0, tx_enable}, 32'h1);
    // R2: full-width value
    rx_pause_valid = 1'b1;
    rx_pause_quanta = 16'hFFFF;
    step("R2");
    chk("R2 full width", peer_stat, 32'h0000FFFF);
    ticks(1, "R5");
    chk("R5 dec", peer_stat, 32'h0000FFFE);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      slot_tick = ($urandom_range(0, 2) == 0);
      rx_pause_valid = ($urandom_range(0, 40) == 0);
      rx_pause_quanta = ($urandom_range(0, 7) == 0) ? TMR_W'($urandom) : TMR_W'($urandom_range(0, 12));
      if ($urandom_range(0, 60) == 0) congested = ~congested;
      pause_sent_ack = ($urandom_range(0, 5) == 0);
      step("R5/R9 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule